// File: doc/BRIEF.md
# Low-Power Real-Time Counter with Seconds Alarm

This block keeps a free-running time count on a slow clock (nominally 32.768 kHz) that is separate from the bus clock. The count is 47 bits wide: the 15 low bits count sub-second ticks and the 32 bits above them count seconds. Software reaches the block through a 32-bit register port on the bus clock. Through it, software reads and loads the count, programs a one-shot seconds alarm, turns on the alarm and wakeup outputs, and reads and clears the alarm flag.

Every control bit is passed into the slow domain through synchronizers. Every value software reads back from the slow domain (the count, the control bits in effect, the flag) comes from a snapshot. The slow domain republishes this snapshot on each of its cycles. A control write therefore shows up in its readback only after the bits have crossed and a new snapshot has returned. Loads of the counter, and writes of the alarm, are accepted or refused based on the enable bits that are actually in effect in the slow domain.

The interrupt line and the wakeup request are both formed in the slow domain. Each is brought into the bus domain through a two-flop synchronizer.

Top module: `lp_rtc`

## Requirements
- R1: While the count enable in effect is 1, the 47-bit counter advances by one on every slow-clock cycle. While it is 0 and no load is pending, the counter holds its value.
- R2: Offset 0x20 reads counter bits 31:0. Offset 0x1C reads counter bits 46:32 in bits 14:0, with zero above. Bits 46:15 form the seconds value.
- R3: The control register is at offset 0x04, with bit 0 = count enable, bit 1 = alarm enable and bit 3 = wakeup enable. Its readback shows the bits in effect in the slow domain. A read issued right after a write still returns the old bits. The new bits appear within a few slow cycles.
- R4: Writes to 0x1C or 0x20 load the counter only while the count enable in effect reads 0. A single-half write keeps the other half. While the count enable in effect reads 1, these writes are ignored.
- R5: The 32-bit alarm at 0x24 takes writes only while the alarm enable in effect reads 0. While it reads 1, writes are ignored.
- R6: Status bit 0 at 0x18 is the alarm flag. It sets when count enable and alarm enable are both in effect and seconds equal the alarm. It stays set until cleared.
- R7: Writing 1 to status bit 0 clears the flag, unless the alarm match still holds, in which case setting wins. Writing 0 leaves the flag unchanged.
- R8: The irq output is the flag ANDed with the alarm enable in effect. The wake output is the flag ANDed with the wakeup enable in effect. Both are re-timed into the bus clock.
- R9: Offset 0x30 is a 32-bit scratch word that reads back what was last written to it, and 0 after reset.
- R10: After reset, control, status and counter read 0, and irq and wake are low. Undefined offsets read 0 and ignore writes.
- R11: Read data appears on bus_rdata one bus cycle after a read request and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Bus-domain reset, active low, asynchronous |
| slow_clk | input | 1 | Slow counting clock |
| slow_rst_n | input | 1 | Slow-domain reset, active low, asynchronous |
| bus_sel | input | 1 | Register access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| irq | output | 1 | Alarm interrupt |
| wake | output | 1 | Wakeup request |

## Verification
Register reads are due exactly one bus cycle after the request. The bench samples them at the falling edge that follows the capturing edge. Control readback, counter loads and flag clears all need two slow edges to cross the synchronizers, plus one more slow edge and about three bus cycles for the snapshot to return. The bench first checks that an immediate read still shows the old value, then polls with a bounded number of reads for the new one. The alarm fires only after the loaded sub-second field rolls over, sixteen slow cycles later, and irq follows one slow cycle and two bus flops after the flag. The bench therefore checks both a lower bound on the bus cycles elapsed before irq rises and a timeout after which irq must have risen.

// File: rtl/lp_rtc_pkg.sv
package lp_rtc_pkg;
    // Register offsets
    localparam int OFF_CTL    = 'h04;
    localparam int OFF_STAT   = 'h18;
    localparam int OFF_CNT_HI = 'h1C;
    localparam int OFF_CNT_LO = 'h20;
    localparam int OFF_ALARM  = 'h24;
    localparam int OFF_GUARD  = 'h30;

    // Control bit positions
    localparam int BIT_CNT_EN  = 0;
    localparam int BIT_ALM_EN  = 1;
    localparam int BIT_WAKE_EN = 3;
    // Status bit positions
    localparam int BIT_FLAG    = 0;

    typedef struct packed {
        logic wake_en;
        logic alarm_en;
        logic cnt_en;
    } ctl_t;
endpackage

// File: rtl/lp_rtc_sync.sv
module lp_rtc_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = d;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q = st_q.s2;
endmodule

// File: rtl/lp_rtc_slow.sv
module lp_rtc_slow
    import lp_rtc_pkg::*;
#(
    parameter  int SUB_W = 15,
    parameter  int SEC_W = 32,
    localparam int CNT_W = SUB_W + SEC_W
) (
    input  logic             slow_clk,
    input  logic             srst_n,
    input  ctl_t             ctl_bus,
    input  logic             ld_tgl,
    input  logic [CNT_W-1:0] ld_val,
    input  logic             clr_tgl,
    input  logic [SEC_W-1:0] alarm,
    output ctl_t             ctl_eff,
    output logic [CNT_W-1:0] cnt,
    output logic             flag,
    output logic             ld_ack,
    output logic             clr_ack,
    output logic             pub,
    output logic             irq_s,
    output logic             wake_s
);
    localparam int SY_W = $bits(ctl_t) + 2;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             flag;
        logic             irq_s;
        logic             wake_s;
        logic             ld_ack;
        logic             clr_ack;
        logic             pub;
    } st_t;

    st_t st_d, st_q;
    logic [SY_W-1:0] sy;
    logic ld_s, clr_s, ld_go, clr_go, match;

    // control bits and request toggles enter the slow domain here
    lp_rtc_sync #(.W(SY_W)) u_in_sync (
        .clk   (slow_clk),
        .rst_n (srst_n),
        .d     ({clr_tgl, ld_tgl, ctl_bus}),
        .q     (sy)
    );

    assign ctl_eff = ctl_t'(sy[$bits(ctl_t)-1:0]);
    assign ld_s    = sy[$bits(ctl_t)];
    assign clr_s   = sy[$bits(ctl_t)+1];
    assign ld_go   = ld_s != st_q.ld_ack;
    assign clr_go  = clr_s != st_q.clr_ack;
    assign match   = ctl_eff.cnt_en && ctl_eff.alarm_en &&
                     (st_q.cnt[CNT_W-1:SUB_W] == alarm);

    always_comb begin
        st_d         = st_q;
        st_d.ld_ack  = ld_s;
        st_d.clr_ack = clr_s;
        st_d.pub     = ~st_q.pub;
        if (ld_go)               st_d.cnt = ld_val;
        else if (ctl_eff.cnt_en) st_d.cnt = st_q.cnt + 1'b1;
        if (match)       st_d.flag = 1'b1;
        else if (clr_go) st_d.flag = 1'b0;
        st_d.irq_s  = st_q.flag & ctl_eff.alarm_en;
        st_d.wake_s = st_q.flag & ctl_eff.wake_en;
    end

    always_ff @(posedge slow_clk or negedge srst_n) begin
        if (!srst_n) st_q <= '0;
        else         st_q <= st_d;
    end

    assign cnt     = st_q.cnt;
    assign flag    = st_q.flag;
    assign ld_ack  = st_q.ld_ack;
    assign clr_ack = st_q.clr_ack;
    assign pub     = st_q.pub;
    assign irq_s   = st_q.irq_s;
    assign wake_s  = st_q.wake_s;

    AST_CNT_HOLD: assert property (@(posedge slow_clk) disable iff (!srst_n)
        (!ctl_eff.cnt_en && !ld_go) |=> $stable(st_q.cnt)); // R1
    AST_FLAG_STICKY: assert property (@(posedge slow_clk) disable iff (!srst_n)
        (st_q.flag && !clr_go) |=> st_q.flag); // R6
    AST_FLAG_CAUSE: assert property (@(posedge slow_clk) disable iff (!srst_n)
        $rose(st_q.flag) |-> $past(ctl_eff.cnt_en && ctl_eff.alarm_en)); // R6
    AST_IRQ_NEEDS_FLAG: assert property (@(posedge slow_clk) disable iff (!srst_n)
        (st_q.irq_s || st_q.wake_s) |-> $past(st_q.flag)); // R8
endmodule

// File: rtl/lp_rtc_regs.sv
module lp_rtc_regs
    import lp_rtc_pkg::*;
#(
    parameter  int SUB_W  = 15,
    parameter  int SEC_W  = 32,
    parameter  int ADDR_W = 8,
    parameter  int DATA_W = 32,
    localparam int CNT_W  = SUB_W + SEC_W,
    localparam int HI_W   = CNT_W - DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              pub_s,
    input  logic [CNT_W-1:0]  s_cnt,
    input  ctl_t              s_ctl,
    input  logic              s_flag,
    input  logic              s_ld_ack,
    input  logic              s_clr_ack,
    output ctl_t              ctl,
    output logic              ld_tgl,
    output logic [CNT_W-1:0]  ld_val,
    output logic              clr_tgl,
    output logic [SEC_W-1:0]  alarm
);
    typedef struct packed {
        ctl_t              ctl;
        logic [SEC_W-1:0]  alarm;
        logic [DATA_W-1:0] guard;
        logic [CNT_W-1:0]  stg;
        logic              ld_tgl;
        logic              ld_redo;
        logic              clr_tgl;
        logic [CNT_W-1:0]  m_cnt;
        ctl_t              m_ctl;
        logic              m_flag;
        logic              m_ld_ack;
        logic              m_clr_ack;
        logic              pub_prev;
        logic [DATA_W-1:0] rdata;
    } st_t;

    st_t st_d, st_q;
    logic wr, rd, cap, inflight, cnt_wr_ok;
    logic [DATA_W-1:0] rv;

    assign wr       = bus_sel && bus_wr;
    assign rd       = bus_sel && !bus_wr;
    assign cap      = pub_s ^ st_q.pub_prev;
    assign inflight = st_q.ld_tgl != st_q.m_ld_ack;

    // read mux works from the last snapshot
    always_comb begin
        rv = '0;
        if (bus_addr == ADDR_W'(OFF_CTL)) begin
            rv[BIT_CNT_EN]  = st_q.m_ctl.cnt_en;
            rv[BIT_ALM_EN]  = st_q.m_ctl.alarm_en;
            rv[BIT_WAKE_EN] = st_q.m_ctl.wake_en;
        end else if (bus_addr == ADDR_W'(OFF_STAT)) begin
            rv[BIT_FLAG] = st_q.m_flag;
        end else if (bus_addr == ADDR_W'(OFF_CNT_HI)) begin
            rv[HI_W-1:0] = st_q.m_cnt[CNT_W-1:DATA_W];
        end else if (bus_addr == ADDR_W'(OFF_CNT_LO)) begin
            rv = st_q.m_cnt[DATA_W-1:0];
        end else if (bus_addr == ADDR_W'(OFF_ALARM)) begin
            rv[SEC_W-1:0] = st_q.alarm;
        end else if (bus_addr == ADDR_W'(OFF_GUARD)) begin
            rv = st_q.guard;
        end
    end

    always_comb begin
        st_d          = st_q;
        cnt_wr_ok     = 1'b0;
        st_d.pub_prev = pub_s;
        if (cap) begin
            st_d.m_cnt     = s_cnt;
            st_d.m_ctl     = s_ctl;
            st_d.m_flag    = s_flag;
            st_d.m_ld_ack  = s_ld_ack;
            st_d.m_clr_ack = s_clr_ack;
        end
        if (wr) begin
            if (bus_addr == ADDR_W'(OFF_CTL)) begin
                st_d.ctl.cnt_en   = bus_wdata[BIT_CNT_EN];
                st_d.ctl.alarm_en = bus_wdata[BIT_ALM_EN];
                st_d.ctl.wake_en  = bus_wdata[BIT_WAKE_EN];
            end else if (bus_addr == ADDR_W'(OFF_STAT)) begin
                if (bus_wdata[BIT_FLAG] && (st_q.clr_tgl == st_q.m_clr_ack))
                    st_d.clr_tgl = ~st_q.clr_tgl;
            end else if (bus_addr == ADDR_W'(OFF_CNT_HI)) begin
                if (!st_q.m_ctl.cnt_en) begin
                    st_d.stg[CNT_W-1:DATA_W] = bus_wdata[HI_W-1:0];
                    cnt_wr_ok = 1'b1;
                end
            end else if (bus_addr == ADDR_W'(OFF_CNT_LO)) begin
                if (!st_q.m_ctl.cnt_en) begin
                    st_d.stg[DATA_W-1:0] = bus_wdata;
                    cnt_wr_ok = 1'b1;
                end
            end else if (bus_addr == ADDR_W'(OFF_ALARM)) begin
                if (!st_q.m_ctl.alarm_en) st_d.alarm = bus_wdata[SEC_W-1:0];
            end else if (bus_addr == ADDR_W'(OFF_GUARD)) begin
                st_d.guard = bus_wdata;
            end
        end
        // load request: one toggle in flight, later writes folded into a redo
        if (cnt_wr_ok || st_q.ld_redo) begin
            if (!inflight) begin
                st_d.ld_tgl  = ~st_q.ld_tgl;
                st_d.ld_redo = 1'b0;
            end else begin
                st_d.ld_redo = 1'b1;
            end
        end else if (cap && !inflight) begin
            st_d.stg = s_cnt;
        end
        if (rd) st_d.rdata = rv;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctl       = st_q.ctl;
    assign ld_tgl    = st_q.ld_tgl;
    assign ld_val    = st_q.stg;
    assign clr_tgl   = st_q.clr_tgl;
    assign alarm     = st_q.alarm;
    assign bus_rdata = st_q.rdata;

    AST_ALARM_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && bus_addr == ADDR_W'(OFF_ALARM) && st_q.m_ctl.alarm_en) |=> $stable(st_q.alarm)); // R5
    AST_CNT_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && (bus_addr == ADDR_W'(OFF_CNT_LO) || bus_addr == ADDR_W'(OFF_CNT_HI)) &&
         st_q.m_ctl.cnt_en && !st_q.ld_redo) |=> $stable(st_q.ld_tgl)); // R4
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> $stable(bus_rdata)); // R11
    AST_GUARD_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && bus_addr == ADDR_W'(OFF_GUARD)) |=> st_q.guard == $past(bus_wdata)); // R9
endmodule

// File: rtl/lp_rtc.sv
module lp_rtc #(
    parameter  int SUB_W  = 15,
    parameter  int SEC_W  = 32,
    parameter  int ADDR_W = 8,
    parameter  int DATA_W = 32,
    localparam int CNT_W  = SUB_W + SEC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slow_clk,
    input  logic              slow_rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq,
    output logic              wake
);
    import lp_rtc_pkg::*;

    ctl_t             ctl_bus, ctl_eff;
    logic             ld_tgl, clr_tgl, flag, ld_ack, clr_ack, pub, irq_s, wake_s;
    logic [CNT_W-1:0] ld_val, cnt;
    logic [SEC_W-1:0] alarm;
    logic [2:0]       back_s;

    lp_rtc_slow #(.SUB_W(SUB_W), .SEC_W(SEC_W)) u_slow (
        .slow_clk (slow_clk),
        .srst_n   (slow_rst_n),
        .ctl_bus  (ctl_bus),
        .ld_tgl   (ld_tgl),
        .ld_val   (ld_val),
        .clr_tgl  (clr_tgl),
        .alarm    (alarm),
        .ctl_eff  (ctl_eff),
        .cnt      (cnt),
        .flag     (flag),
        .ld_ack   (ld_ack),
        .clr_ack  (clr_ack),
        .pub      (pub),
        .irq_s    (irq_s),
        .wake_s   (wake_s)
    );

    // publish toggle and output requests into the bus clock
    lp_rtc_sync #(.W(3)) u_back_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({pub, irq_s, wake_s}),
        .q     (back_s)
    );

    lp_rtc_regs #(
        .SUB_W (SUB_W), .SEC_W (SEC_W), .ADDR_W (ADDR_W), .DATA_W (DATA_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pub_s     (back_s[2]),
        .s_cnt     (cnt),
        .s_ctl     (ctl_eff),
        .s_flag    (flag),
        .s_ld_ack  (ld_ack),
        .s_clr_ack (clr_ack),
        .ctl       (ctl_bus),
        .ld_tgl    (ld_tgl),
        .ld_val    (ld_val),
        .clr_tgl   (clr_tgl),
        .alarm     (alarm)
    );

    assign irq  = back_s[1];
    assign wake = back_s[0];
endmodule

// File: tb/lp_rtc_tb_top.sv
module lp_rtc_tb_top;
    logic        clk = 0, slow_clk = 0, rst_n = 0, slow_rst_n = 0;
    logic        bus_sel = 0, bus_wr = 0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq, wake;
    int total = 0, bad = 0;
    bit done = 0;

    always #5 clk = ~clk;
    always #85 slow_clk = ~slow_clk;

    lp_rtc dut_i (
        .clk(clk), .rst_n(rst_n), .slow_clk(slow_clk), .slow_rst_n(slow_rst_n),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .wake(wake)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_sel = 0; bus_wr = 0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk); bus_sel = 1; bus_wr = 0; bus_addr = a;
        @(negedge clk); bus_sel = 0;
        d = bus_rdata;
    endtask

    task automatic poll(input logic [7:0] a, input logic [31:0] exp, input int max, output logic [31:0] got);
        for (int i = 0; i < max; i++) begin
            rd(a, got);
            if (got == exp) break;
        end
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(8'h04, v); check(v == 0, "R10 ctl after reset", v, 0);
        rd(8'h18, v); check(v == 0, "R10 status after reset", v, 0);
        rd(8'h1C, v); check(v == 0, "R10 count high after reset", v, 0);
        rd(8'h20, v); check(v == 0, "R10 count low after reset", v, 0);
        rd(8'h30, v); check(v == 0, "R9 scratch after reset", v, 0);
        check(irq == 0 && wake == 0, "R10 outputs after reset", {irq, wake}, 0);
    endtask

    task automatic t_scratch_and_holes();
        logic [31:0] v, w;
        wr(8'h30, 32'h4173_6166); rd(8'h30, v);
        check(v == 32'h4173_6166, "R9 scratch readback", v, 32'h4173_6166);
        wr(8'h30, 32'h0F0F_A5A5); rd(8'h30, v);
        check(v == 32'h0F0F_A5A5, "R9 scratch second value", v, 32'h0F0F_A5A5);
        wr(8'h08, 32'hFFFF_FFFF); rd(8'h08, v);
        check(v == 0, "R10 hole reads zero", v, 0);
        rd(8'h04, v); check(v == 0, "R10 hole write left ctl", v, 0);
        rd(8'h30, v);
        repeat (5) @(negedge clk);
        w = bus_rdata;
        check(w == v, "R11 read data holds", w, v);
    endtask

    task automatic t_ctl_lag_and_count();
        logic [31:0] v, a, b;
        wr(8'h04, 32'h1); rd(8'h04, v);
        check(v == 0, "R3 immediate readback still old", v, 0);
        poll(8'h04, 32'h1, 200, v);
        check(v == 1, "R3 readback reaches written bit", v, 1);
        rd(8'h20, a);
        repeat (20) @(posedge slow_clk);
        rd(8'h20, b);
        check((b - a) >= 17 && (b - a) <= 23, "R1 count advance per slow cycle", b - a, 20);
        wr(8'h20, 32'hFFFF_0000);
        repeat (10) @(posedge slow_clk);
        rd(8'h20, v);
        check(v < 32'h1_0000, "R4 load ignored while counting", v, 0);
        wr(8'h04, 32'h0); poll(8'h04, 32'h0, 200, v);
        check(v == 0, "R3 readback of disable", v, 0);
        rd(8'h20, a);
        repeat (10) @(posedge slow_clk);
        rd(8'h20, b);
        check(a == b, "R1 count holds when disabled", b, a);
    endtask

    task automatic t_load();
        logic [31:0] v;
        wr(8'h1C, 32'h5);
        wr(8'h20, 32'hABCD_0000);
        poll(8'h20, 32'hABCD_0000, 200, v);
        check(v == 32'hABCD_0000, "R4 low half loaded", v, 32'hABCD_0000);
        rd(8'h1C, v);
        check(v == 32'h5, "R2 high half loaded", v, 5);
        wr(8'h20, 32'h1234_5678);
        poll(8'h20, 32'h1234_5678, 200, v);
        rd(8'h1C, v);
        check(v == 32'h5, "R4 single-half load keeps other half", v, 5);
    endtask

    task automatic t_fire(input bit wk, input logic [31:0] t);
        logic [31:0] v, hi, lo;
        logic [63:0] c;
        logic [46:0] full;
        int n;
        bit wake_seen;
        wr(8'h04, 32'h0); poll(8'h04, 32'h0, 200, v);
        c = ({32'd0, t - 32'd1} << 15) | 64'h7FF0;
        wr(8'h1C, c[63:32]); wr(8'h20, c[31:0]);
        poll(8'h20, c[31:0], 200, v);
        rd(8'h1C, v);
        check(v == c[63:32], "R2 high half before alarm", v, c[63:32]);
        wr(8'h24, t); rd(8'h24, v);
        check(v == t, "R5 alarm write accepted while off", v, t);
        wr(8'h18, 32'h1); poll(8'h18, 32'h0, 200, v);
        wr(8'h04, wk ? 32'hB : 32'h3);
        n = 0; wake_seen = 0;
        while (irq == 0 && n < 3000) begin
            @(negedge clk); n++;
            if (wake) wake_seen = 1;
        end
        check(irq == 1, "R6 alarm raises irq", irq, 1);
        check(n >= 150, "R6 no fire before seconds match", n, 150);
        check(wake == wk && (wk || !wake_seen), "R8 wake follows enable", wake, wk);
        rd(8'h18, v); check(v == 1, "R6 flag set", v, 1);
        rd(8'h1C, hi); rd(8'h20, lo);
        full = {hi[14:0], lo};
        check(full[46:15] == t, "R2 seconds field equals alarm", full[46:15], t);
    endtask

    task automatic t_clear();
        logic [31:0] v;
        int n;
        wr(8'h04, 32'h1); poll(8'h04, 32'h1, 200, v);
        n = 0;
        while ((irq || wake) && n < 300) begin @(negedge clk); n++; end
        check(irq == 0 && wake == 0, "R8 outputs drop with enables", {irq, wake}, 0);
        rd(8'h18, v); check(v == 1, "R6 flag stays set", v, 1);
        wr(8'h18, 32'h0);
        repeat (10) @(posedge slow_clk);
        rd(8'h18, v); check(v == 1, "R7 writing zero keeps flag", v, 1);
        wr(8'h18, 32'h1); poll(8'h18, 32'h0, 200, v);
        check(v == 0, "R7 writing one clears flag", v, 0);
    endtask

    task automatic t_alarm_lock(input logic [31:0] prev);
        logic [31:0] v;
        wr(8'h04, 32'h2); poll(8'h04, 32'h2, 200, v);
        wr(8'h24, 32'hDEAD_BEEF); rd(8'h24, v);
        check(v == prev, "R5 alarm write ignored while enabled", v, prev);
        wr(8'h04, 32'h0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1; slow_rst_n = 1;
        repeat (4) @(negedge clk);
        t_reset();
        t_scratch_and_holes();
        t_ctl_lag_and_count();
        t_load();
        t_fire(1'b1, 32'h0012_3456);
        t_clear();
        t_fire(1'b0, 32'hFFFF_FFF0);
        t_clear();
        t_alarm_lock(32'hFFFF_FFF0);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule